// File: doc/BRIEF.md
# Operand Wakeup Instruction Window

This block holds the instructions that a dynamically scheduled core has handed over and not yet finished with. Slots are filled in program order at the tail of a circular buffer. Each slot records up to `NSRC` source operand tags, and each tag has its own ready flag. Every cycle, all `NCOMP` result broadcast ports are compared against every waiting operand of every slot. An operand whose tag matches any valid broadcast is marked ready. The default size is 80 slots, 6 ports and 2 operands, which gives 960 tag comparators working in parallel.

A slot whose operands are all ready is flagged in `ready_vec`. Picking among the flagged slots is left to an external scheduler. When execution of a slot finishes, the scheduler reports it on the finish port with the slot number. Slots leave the window only in program order. The head slot is released in the cycle in which it is finished, or in any later cycle. A younger slot that finishes early stays in the window until it becomes the head. Allocation is refused while every slot is occupied.

Top module: `inst_wakeup_window`

## Requirements
- R1: After reset the window is empty: `occupancy` is 0, `full` is 0, `ready_vec` is all zeros, and both `head_slot` and `alloc_slot` are 0.
- R2: When `alloc_valid` is 1 and `full` is 0, the instruction is written into slot `alloc_slot`. At that clock edge `alloc_slot` advances by one, wrapping from DEPTH-1 to 0.
- R3: `full` is 1 exactly when `occupancy` equals DEPTH. While `full` is 1, `alloc_valid` is ignored: no slot is written and `alloc_slot` does not move.
- R4: A waiting operand of an occupied slot becomes ready at the clock edge at which its tag equals the tag of any broadcast port whose valid bit is 1. Ports whose valid bit is 0 wake nothing. Port p carries its tag in `bcast_tags[p*TAG_W +: TAG_W]`.
- R5: If an allocated operand's tag matches a valid broadcast in the same cycle as its allocation, the operand is written as already ready.
- R6: Operand s is taken from `alloc_tags[s*TAG_W +: TAG_W]`. It is written as ready when `alloc_used[s]` is 0 (the operand is absent) or when `alloc_pre_rdy[s]` is 1.
- R7: `ready_vec[i]` is 1 exactly when slot i is occupied and all of its operand ready flags are 1. Ready flags never clear while the slot is occupied.
- R8: The head slot is released when it is occupied and finished. A slot counts as finished if `fin_valid` with `fin_slot` equal to that slot was given in the current cycle or in an earlier cycle. At most one slot is released per cycle. A finished slot that is not the head is kept. `occupancy` changes by the number of allocations minus the number of releases.
- R9: On each release, `head_slot` advances by one, wrapping from DEPTH-1 to 0.
- R10: A finish report naming a slot that is not occupied has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to place an instruction at the tail |
| alloc_used | input | NSRC | Operand present flags for the new instruction |
| alloc_pre_rdy | input | NSRC | Operand already available at allocation |
| alloc_tags | input | NSRC*TAG_W | Source tags of the new instruction, operand s in bits s*TAG_W upward |
| alloc_slot | output | IDX_W | Slot that the next allocation fills (the tail) |
| bcast_valid | input | NCOMP | Valid bit per result broadcast port |
| bcast_tags | input | NCOMP*TAG_W | Destination tag per broadcast port |
| fin_valid | input | 1 | Execution of slot `fin_slot` has finished |
| fin_slot | input | IDX_W | Slot number being finished |
| ready_vec | output | DEPTH | Occupied slots whose operands are all ready |
| occupancy | output | CNT_W | Number of occupied slots |
| full | output | 1 | All slots occupied |
| head_slot | output | IDX_W | Oldest occupied slot |

## Verification
The bench uses a four-slot, two-port, three-bit-tag configuration, so random tags collide often. A bench-side model of the slots is compared at every cycle. One phase sends broadcasts with valid bits 0 or 1 against fully waiting operands, which separates real wakeups from those caused by ignored ports. Another phase copies a broadcast tag into the instruction being allocated in the same cycle, to catch a wakeup lost at allocation time. Further phases vary the absent and pre-ready flags, hold the window full while still requesting allocation, finish slots out of order, and aim finish reports at empty slots. These phases separate head-only, in-order release from premature release, and exercise wrap-around of both pointers.

// File: rtl/win_pkg.sv
package win_pkg;

    // Advance a circular buffer index by one slot.
    function automatic int unsigned ring_step(int unsigned p, int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/win_tag_match.sv
module win_tag_match #(
    parameter int NPORT = 6,
    parameter int TAG_W = 7
) (
    input  logic [TAG_W-1:0]       probe,
    input  logic [NPORT-1:0]       bc_valid,
    input  logic [NPORT*TAG_W-1:0] bc_tags,
    output logic                   hit
);
    logic [NPORT-1:0] eq;

    // One equality comparator per broadcast port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign eq[p] = bc_valid[p] && (bc_tags[p*TAG_W +: TAG_W] == probe);
    end

    assign hit = |eq;
endmodule

// File: rtl/win_ring_ctl.sv
module win_ring_ctl #(
    parameter int DEPTH = 80,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ring_t;

    ring_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (push) begin
            r_d.tail = IDX_W'(win_pkg::ring_step(int'(r_q.tail), DEPTH));
        end
        if (pop) begin
            r_d.head = IDX_W'(win_pkg::ring_step(int'(r_q.head), DEPTH));
        end
        r_d.count = r_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign head  = r_q.head;
    assign tail  = r_q.tail;
    assign count = r_q.count;
    assign full  = (r_q.count == CNT_W'(DEPTH));
endmodule

// File: rtl/inst_wakeup_window.sv
module inst_wakeup_window #(
    parameter int DEPTH = 80,
    parameter int NCOMP = 6,
    parameter int NSRC  = 2,
    parameter int TAG_W = 7,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  logic [NSRC-1:0]        alloc_used,
    input  logic [NSRC-1:0]        alloc_pre_rdy,
    input  logic [NSRC*TAG_W-1:0]  alloc_tags,
    output logic [IDX_W-1:0]       alloc_slot,
    input  logic [NCOMP-1:0]       bcast_valid,
    input  logic [NCOMP*TAG_W-1:0] bcast_tags,
    input  logic                   fin_valid,
    input  logic [IDX_W-1:0]       fin_slot,
    output logic [DEPTH-1:0]       ready_vec,
    output logic [CNT_W-1:0]       occupancy,
    output logic                   full,
    output logic [IDX_W-1:0]       head_slot
);
    typedef struct packed {
        logic [DEPTH-1:0]                       vld;
        logic [DEPTH-1:0]                       fin;
        logic [DEPTH-1:0][NSRC-1:0]             rdy;
        logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0]  tag;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [DEPTH-1:0][NSRC-1:0] op_hit;
    logic [NSRC-1:0]            new_hit;
    logic [IDX_W-1:0]           head, tail;
    logic                       push, pop;
    logic                       head_fin_now;

    // Comparator array: every slot operand against every broadcast port.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            win_tag_match #(.NPORT(NCOMP), .TAG_W(TAG_W)) u_match (
                .probe    (st_q.tag[e][s]),
                .bc_valid (bcast_valid),
                .bc_tags  (bcast_tags),
                .hit      (op_hit[e][s])
            );
        end
    end

    // Comparators for the operands arriving on the allocate port.
    for (genvar s = 0; s < NSRC; s++) begin : g_new
        win_tag_match #(.NPORT(NCOMP), .TAG_W(TAG_W)) u_match_new (
            .probe    (alloc_tags[s*TAG_W +: TAG_W]),
            .bc_valid (bcast_valid),
            .bc_tags  (bcast_tags),
            .hit      (new_hit[s])
        );
    end

    win_ring_ctl #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .count (occupancy),
        .full  (full)
    );

    assign push         = alloc_valid && !full;
    assign head_fin_now = fin_valid && (fin_slot == head);
    assign pop          = st_q.vld[head] && (st_q.fin[head] || head_fin_now);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.vld[i]) begin
                // Wakeup: ready flags only ever gain bits while occupied.
                st_d.rdy[i] = st_q.rdy[i] | op_hit[i];
                if (fin_valid && (fin_slot == IDX_W'(i))) begin
                    st_d.fin[i] = 1'b1;
                end
            end
            if (pop && (head == IDX_W'(i))) begin
                st_d.vld[i] = 1'b0;
                st_d.fin[i] = 1'b0;
                st_d.rdy[i] = '0;
            end
            if (push && (tail == IDX_W'(i))) begin
                st_d.vld[i] = 1'b1;
                st_d.fin[i] = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    st_d.tag[i][s] = alloc_tags[s*TAG_W +: TAG_W];
                    st_d.rdy[i][s] = !alloc_used[s] || alloc_pre_rdy[s] || new_hit[s];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_rdy
        assign ready_vec[e] = st_q.vld[e] && (&st_q.rdy[e]);
    end

    assign alloc_slot = tail;
    assign head_slot  = head;
endmodule

// File: rtl/inst_wakeup_window_chk.sv
module inst_wakeup_window_chk #(
    parameter int DEPTH = 80,
    parameter int IDX_W = 7,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             full,
    input logic [CNT_W-1:0] occupancy,
    input logic [IDX_W-1:0] alloc_slot,
    input logic [IDX_W-1:0] head_slot,
    input logic [DEPTH-1:0] ready_vec
);
    function automatic logic [IDX_W-1:0] nxt(logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid) |=> (occupancy <= $past(occupancy)));

    // R8
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == $past(occupancy)) ||
        (occupancy == $past(occupancy) + CNT_W'(1)) ||
        (occupancy + CNT_W'(1) == $past(occupancy)));

    // R7
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> (ready_vec == '0));

    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full) |=> (alloc_slot == nxt($past(alloc_slot))));

    // R9
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_slot != $past(head_slot)) |-> (head_slot == nxt($past(head_slot))));
endmodule

bind inst_wakeup_window inst_wakeup_window_chk #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .full        (full),
    .occupancy   (occupancy),
    .alloc_slot  (alloc_slot),
    .head_slot   (head_slot),
    .ready_vec   (ready_vec)
);

// File: tb/tb_inst_wakeup_window.sv
module tb_inst_wakeup_window;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int NCOMP = 2;
    localparam int NSRC  = 2;
    localparam int TAG_W = 3;
    localparam int IDX_W = 2;
    localparam int CNT_W = 3;
    localparam int PHASE_CYC = 500;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   alloc_valid = 1'b0;
    logic [NSRC-1:0]        alloc_used = '0;
    logic [NSRC-1:0]        alloc_pre_rdy = '0;
    logic [NSRC*TAG_W-1:0]  alloc_tags = '0;
    logic [IDX_W-1:0]       alloc_slot;
    logic [NCOMP-1:0]       bcast_valid = '0;
    logic [NCOMP*TAG_W-1:0] bcast_tags = '0;
    logic                   fin_valid = 1'b0;
    logic [IDX_W-1:0]       fin_slot = '0;
    logic [DEPTH-1:0]       ready_vec;
    logic [CNT_W-1:0]       occupancy;
    logic                   full;
    logic [IDX_W-1:0]       head_slot;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    bit             m_vld [DEPTH];
    bit             m_fin [DEPTH];
    bit             m_rdy [DEPTH][NSRC];
    bit [TAG_W-1:0] m_tag [DEPTH][NSRC];
    int             m_head = 0;
    int             m_tail = 0;
    int             m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inst_wakeup_window #(.DEPTH(DEPTH), .NCOMP(NCOMP), .NSRC(NSRC), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_used(alloc_used),
        .alloc_pre_rdy(alloc_pre_rdy), .alloc_tags(alloc_tags), .alloc_slot(alloc_slot),
        .bcast_valid(bcast_valid), .bcast_tags(bcast_tags), .fin_valid(fin_valid),
        .fin_slot(fin_slot), .ready_vec(ready_vec), .occupancy(occupancy), .full(full),
        .head_slot(head_slot)
    );

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s): actual %0d expected %0d at %0t", req, cur_req, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    function automatic bit bhit(bit [TAG_W-1:0] t);
        for (int p = 0; p < NCOMP; p++) begin
            if (bcast_valid[p] && bcast_tags[p*TAG_W +: TAG_W] == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Reference behaviour at one clock edge, from the requirements.
    task automatic model_step();
        bit ret;
        bit psh;
        ret = (m_cnt > 0) && m_vld[m_head] &&
              (m_fin[m_head] || (fin_valid && int'(fin_slot) == m_head));
        psh = alloc_valid && (m_cnt < DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i]) begin
                for (int s = 0; s < NSRC; s++) if (bhit(m_tag[i][s])) m_rdy[i][s] = 1'b1;
                if (fin_valid && int'(fin_slot) == i) m_fin[i] = 1'b1;
            end
        end
        if (ret) begin
            m_vld[m_head] = 1'b0;
            m_fin[m_head] = 1'b0;
            m_head = (m_head + 1) % DEPTH;
        end
        if (psh) begin
            m_vld[m_tail] = 1'b1;
            m_fin[m_tail] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                m_tag[m_tail][s] = alloc_tags[s*TAG_W +: TAG_W];
                m_rdy[m_tail][s] = !alloc_used[s] || alloc_pre_rdy[s] ||
                                   bhit(alloc_tags[s*TAG_W +: TAG_W]);
            end
            m_tail = (m_tail + 1) % DEPTH;
        end
        m_cnt = m_cnt + int'(psh) - int'(ret);
    endtask

    task automatic compare_all();
        int exp_vec;
        exp_vec = 0;
        for (int i = 0; i < DEPTH; i++) begin
            bit all_r;
            all_r = m_vld[i];
            for (int s = 0; s < NSRC; s++) all_r &= m_rdy[i][s];
            if (all_r) exp_vec |= (1 << i);
        end
        check("R7 ready_vec", int'(ready_vec), exp_vec);
        check("R8 occupancy", int'(occupancy), m_cnt);
        check("R3 full", int'(full), int'(m_cnt == DEPTH));
        check("R9 head_slot", int'(head_slot), m_head);
        check("R2 alloc_slot", int'(alloc_slot), m_tail);
    endtask

    // Stimulus for one cycle; the phase selects the pattern.
    task automatic gen(int ph, int cyc);
        alloc_valid   = 1'b0;
        fin_valid     = 1'b0;
        alloc_used    = '1;
        alloc_pre_rdy = '0;
        bcast_valid   = '0;
        for (int p = 0; p < NCOMP; p++) begin
            bcast_tags[p*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, (1 << TAG_W) - 1));
            bcast_valid[p] = ($urandom_range(0, 99) < 40);
        end
        for (int s = 0; s < NSRC; s++)
            alloc_tags[s*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, (1 << TAG_W) - 1));
        fin_slot = IDX_W'($urandom_range(0, DEPTH - 1));
        case (ph)
            4: begin // R4: waiting operands, mixed valid/invalid broadcasts
                alloc_valid = ($urandom_range(0, 99) < 40);
                fin_valid   = ($urandom_range(0, 99) < 30);
            end
            5: begin // R5: allocation tags copied from this cycle's broadcasts
                alloc_valid = ($urandom_range(0, 99) < 60);
                bcast_valid[0] = 1'b1;
                for (int s = 0; s < NSRC; s++) begin
                    int p;
                    p = $urandom_range(0, NCOMP - 1);
                    alloc_tags[s*TAG_W +: TAG_W] = bcast_tags[p*TAG_W +: TAG_W];
                end
                fin_valid = ($urandom_range(0, 99) < 45);
            end
            6: begin // R6: absent or pre-ready operands, no broadcasts
                bcast_valid   = '0;
                alloc_valid   = ($urandom_range(0, 99) < 60);
                alloc_used    = NSRC'($urandom_range(0, (1 << NSRC) - 1));
                alloc_pre_rdy = NSRC'($urandom_range(0, (1 << NSRC) - 1));
                fin_valid     = ($urandom_range(0, 99) < 45);
            end
            3: begin // R3: allocation pressure with sparse finishing
                alloc_valid = 1'b1;
                fin_valid   = ((cyc % 9) == 8);
            end
            8: begin // R8/R9: out-of-order finishing
                alloc_valid = ($urandom_range(0, 99) < 55);
                fin_valid   = ($urandom_range(0, 99) < 70);
            end
            default: begin // R10: finish reports aimed at empty slots
                alloc_valid = ($urandom_range(0, 99) < 50);
                fin_valid   = 1'b0;
                if ((cyc % 3) == 0) begin
                    fin_valid = ($urandom_range(0, 99) < 60);
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!m_vld[i]) begin
                            fin_valid = 1'b1;
                            fin_slot  = IDX_W'(i);
                        end
                    end
                end
            end
        endcase
    endtask

    task automatic run_phase(string name, int ph);
        cur_req = name;
        for (int c = 0; c < PHASE_CYC; c++) begin
            gen(ph, c);
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 1'b0;
            m_fin[i] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                m_rdy[i][s] = 1'b0;
                m_tag[i][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 occupancy", int'(occupancy), 0);
        check("R1 full", int'(full), 0);
        check("R1 ready_vec", int'(ready_vec), 0);
        check("R1 head_slot", int'(head_slot), 0);
        check("R1 alloc_slot", int'(alloc_slot), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_phase("R4", 4);
        run_phase("R5", 5);
        run_phase("R6", 6);
        run_phase("R3", 3);
        run_phase("R8", 8);
        run_phase("R10", 10);
        run_phase("R4", 4);
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog (phase %s): actual timeout expected completion", cur_req);
        summary();
        $finish;
    end
endmodule